// File: doc/BRIEF.md
# Mailbox Status-Transfer Handshake Controller

This block is the device side of a byte-wide host register interface. A host asks for a copy of the device status by writing a request code into the host-to-device command register. The controller then does four things in order. It captures all status bytes from a parallel source in a single cycle. It copies them one byte per cycle into a small mailbox that the host can read. It clears the host's pending request. Finally it posts a response code in the device-to-host register, which raises the interrupt line.

The exchange ends when the host writes an acknowledge code into the command register. The host may first clear the device-to-host register, which drops the interrupt. That step is optional, and the exchange completes either way. Request codes that arrive while an exchange is still open are dropped. Command values outside the request and acknowledge codes are ignored.

Each status byte sits in the mailbox at its own index, so the mailbox has the same byte layout as the status source.

Top module: `mbox_status_ctrl`

## Requirements
- R1: After reset the interrupt output is low, reads of the command register (0x50) and of the response register (0x58) return 0x00, and every mailbox byte (addresses 0x00 to NUM_STAT-1) reads 0x00.
- R2: While idle, a host write of 0x33 to 0x50 is accepted. In the next cycle, a read of 0x50 returns 0x33 and stays at 0x33 until the request is served.
- R3: The status bytes are captured on the clock edge that follows the accepting edge. Mailbox address i then holds status byte i, which is bits [8i+7:8i] of the status input, as it was at that edge. Later changes of the status input do not reach the mailbox.
- R4: The request is served on the edge NUM_STAT+2 cycles after the accepting edge, and not before. After that edge, 0x50 reads 0x00, 0x58 reads 0x34 and the interrupt is high.
- R5: The interrupt is high exactly while the device-pending flag (0x58 reads 0x34) is set. It stays high with no host action.
- R6: Any host write to 0x58 while a response is posted clears the flag. In the next cycle the interrupt is low and 0x58 reads 0x00. The exchange still completes on a later acknowledge.
- R7: A write of 0x35 to 0x50 while a response is open makes 0x50 read 0x35 for one cycle. On the next edge, 0x50 and 0x58 both read 0x00, the interrupt is low and the controller is idle again, so it accepts a new 0x33.
- R8: A 0x33 written while an exchange is open is ignored: 0x50 keeps reading 0x00, the mailbox keeps its contents and the interrupt keeps its level.
- R9: While idle, a write to 0x50 of any value other than 0x33 is ignored: 0x50 keeps reading 0x00 and the interrupt stays low.
- R10: If a host write to 0x58 falls on the same edge that posts the response, posting wins: the interrupt is high afterwards and 0x58 reads 0x34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe; read data is combinational |
| host_rdata | output | DATA_W | Read data, zero when no read is active |
| stat_in | input | NUM_STAT*DATA_W | Parallel status bytes, byte 0 in the low bits |
| irq | output | 1 | Interrupt to host, active high |

## Verification
Two events can meet on one clock edge: the controller posting its response, which sets the device-pending flag, and a host write to the response register, which clears that flag. The bench counts the cycles from the accepted request and places a clear write exactly on the posting edge. It then expects the interrupt high and 0x34 readable, because a lost response would stall the exchange. The same runs also change the status input right after the capture edge, and check that the mailbox keeps the captured values while the bytes are copied out.

// File: rtl/mbxh_pkg.sv
package mbxh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_COPY,
    ST_NOTE,
    ST_WAIT,
    ST_ACKD
  } hs_state_e;

  function automatic logic in_window(input int unsigned a,
                                     input int unsigned base,
                                     input int unsigned cnt);
    return (a >= base) && (a < base + cnt);
  endfunction

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mbxh_snap.sv
module mbxh_snap #(
  parameter int DATA_W   = 8,
  parameter int NUM_STAT = 4,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [NUM_STAT*DATA_W-1:0] stat_in,
  input  logic [IDX_W-1:0]           sel_idx,
  output logic [DATA_W-1:0]          sel_byte
);

  logic [DATA_W-1:0] shadow [NUM_STAT];

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow[g] <= '0;
      else if (cap_en) shadow[g] <= stat_in[g*DATA_W +: DATA_W];
    end
  end

  assign sel_byte = shadow[sel_idx];

endmodule

// File: rtl/mbxh_ram.sv
module mbxh_ram #(
  parameter int DATA_W   = 8,
  parameter int NUM_STAT = 4,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NUM_STAT];

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (we && widx == IDX_W'(g))  mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/mbxh_fsm.sv
module mbxh_fsm
  import mbxh_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_STAT = 4,
  parameter int IDX_W    = 2,
  parameter int CODE_REQ = 'h33,
  parameter int CODE_RSP = 'h34,
  parameter int CODE_ACK = 'h35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              ack_wr,
  input  logic              dclr_wr,
  output logic              cap_en,
  output logic              mbx_we,
  output logic [IDX_W-1:0]  mbx_idx,
  output logic [DATA_W-1:0] h2d_code,
  output logic [DATA_W-1:0] d2h_code,
  output logic              hpend,
  output logic              dpend,
  output logic              busy,
  output logic              req_accept,
  output logic              ack_accept,
  output logic              notify_ev,
  output logic              ack_ev
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STAT - 1);

  hs_state_e state;

  assign busy       = (state != ST_IDLE);
  assign cap_en     = (state == ST_CAPT);
  assign mbx_we     = (state == ST_COPY);
  assign notify_ev  = (state == ST_NOTE);
  assign ack_ev     = (state == ST_ACKD);
  assign req_accept = req_wr && (state == ST_IDLE);
  assign ack_accept = ack_wr && (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mbx_idx  <= '0;
      h2d_code <= '0;
      d2h_code <= '0;
      hpend    <= 1'b0;
      dpend    <= 1'b0;
    end else begin
      // host clear of the response flag; a posting edge overrides it below
      if (dclr_wr) begin
        dpend    <= 1'b0;
        d2h_code <= '0;
      end
      unique case (state)
        ST_IDLE: if (req_accept) begin
          h2d_code <= DATA_W'(CODE_REQ);
          hpend    <= 1'b1;
          state    <= ST_CAPT;
        end
        ST_CAPT: begin
          mbx_idx <= '0;
          state   <= ST_COPY;
        end
        ST_COPY: begin
          if (mbx_idx == LAST_IDX) state <= ST_NOTE;
          else                     mbx_idx <= mbx_idx + 1'b1;
        end
        ST_NOTE: begin
          hpend    <= 1'b0;
          h2d_code <= '0;
          d2h_code <= DATA_W'(CODE_RSP);
          dpend    <= 1'b1;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (ack_accept) begin
          h2d_code <= DATA_W'(CODE_ACK);
          hpend    <= 1'b1;
          state    <= ST_ACKD;
        end
        ST_ACKD: begin
          hpend    <= 1'b0;
          h2d_code <= '0;
          dpend    <= 1'b0;
          d2h_code <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_status_ctrl.sv
module mbox_status_ctrl
  import mbxh_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter int          NUM_STAT  = 4,
  parameter int unsigned MBX_BASE  = 'h00,
  parameter int unsigned CMD_ADDR  = 'h50,
  parameter int unsigned RSP_ADDR  = 'h58,
  parameter int          CODE_REQ  = 'h33,
  parameter int          CODE_RSP  = 'h34,
  parameter int          CODE_ACK  = 'h35
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [DATA_W-1:0]          host_wdata,
  input  logic                       host_wr,
  input  logic                       host_rd,
  output logic [DATA_W-1:0]          host_rdata,
  input  logic [NUM_STAT*DATA_W-1:0] stat_in,
  output logic                       irq
);

  localparam int IDX_W = idx_bits(NUM_STAT);

  logic              at_cmd, at_rsp, at_mbx;
  logic              req_wr, ack_wr, dclr_wr;
  logic              cap_en, mbx_we, busy;
  logic              hpend, dpend;
  logic              req_accept, ack_accept, notify_ev, ack_ev;
  logic [IDX_W-1:0]  mbx_idx, rd_idx;
  logic [DATA_W-1:0] snap_byte, mbx_rdata, h2d_code, d2h_code;

  assign at_cmd  = (32'(host_addr) == CMD_ADDR);
  assign at_rsp  = (32'(host_addr) == RSP_ADDR);
  assign at_mbx  = in_window(32'(host_addr), MBX_BASE, NUM_STAT);
  assign rd_idx  = IDX_W'(32'(host_addr) - MBX_BASE);

  assign req_wr  = host_wr && at_cmd && (host_wdata == DATA_W'(CODE_REQ));
  assign ack_wr  = host_wr && at_cmd && (host_wdata == DATA_W'(CODE_ACK));
  assign dclr_wr = host_wr && at_rsp;

  mbxh_fsm #(
    .DATA_W(DATA_W), .NUM_STAT(NUM_STAT), .IDX_W(IDX_W),
    .CODE_REQ(CODE_REQ), .CODE_RSP(CODE_RSP), .CODE_ACK(CODE_ACK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_wr(req_wr), .ack_wr(ack_wr), .dclr_wr(dclr_wr),
    .cap_en(cap_en), .mbx_we(mbx_we), .mbx_idx(mbx_idx),
    .h2d_code(h2d_code), .d2h_code(d2h_code),
    .hpend(hpend), .dpend(dpend), .busy(busy),
    .req_accept(req_accept), .ack_accept(ack_accept),
    .notify_ev(notify_ev), .ack_ev(ack_ev)
  );

  mbxh_snap #(.DATA_W(DATA_W), .NUM_STAT(NUM_STAT), .IDX_W(IDX_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .stat_in(stat_in),
    .sel_idx(mbx_idx), .sel_byte(snap_byte)
  );

  mbxh_ram #(.DATA_W(DATA_W), .NUM_STAT(NUM_STAT), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(mbx_we), .widx(mbx_idx),
    .wdata(snap_byte), .ridx(rd_idx), .rdata(mbx_rdata)
  );

  assign irq = dpend;

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (at_cmd)      host_rdata = h2d_code;
      else if (at_rsp) host_rdata = d2h_code;
      else if (at_mbx) host_rdata = mbx_rdata;
    end
  end

endmodule

// File: rtl/mbox_status_ctrl_chk.sv
module mbox_status_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic hpend,
  input logic busy,
  input logic req_accept,
  input logic ack_accept,
  input logic notify_ev,
  input logic ack_ev,
  input logic dclr_wr,
  input logic mbx_we
);

  a_r2_req_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (hpend && busy));

  a_r4_post_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    notify_ev |=> (irq && !hpend));

  a_r10_post_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_ev && dclr_wr) |=> irq);

  a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (dclr_wr && !notify_ev) |=> !irq);

  a_r7_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev |=> (!irq && !hpend && !busy));

  a_r7_ack_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack_accept |=> hpend);

  a_r8_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_accept);

  a_r5_irq_only_in_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);

  a_r3_copy_before_post: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_we |-> (busy && !irq));

endmodule

bind mbox_status_ctrl mbox_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .hpend(hpend), .busy(busy),
  .req_accept(req_accept), .ack_accept(ack_accept), .notify_ev(notify_ev),
  .ack_ev(ack_ev), .dclr_wr(dclr_wr), .mbx_we(mbx_we)
);

// File: tb/mbox_status_ctrl_test.sv
module mbox_status_ctrl_test;

  localparam int CLK_NS = 10;
  localparam int NS     = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       host_addr = '0;
  logic [7:0]       host_wdata = '0;
  logic             host_wr = 1'b0;
  logic             host_rd = 1'b0;
  logic [7:0]       host_rdata;
  logic [NS*8-1:0]  stat_in = '0;
  logic             irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mbox_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .stat_in(stat_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1;
    d = host_rdata;
    host_rd = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 53 + i * 29 + 7) & 255);
  endfunction

  task automatic check_mbx(input string tag, input logic [7:0] exp [NS]);
    logic [7:0] v;
    for (int i = 0; i < NS; i++) begin
      rd(8'(i), v);
      chk(tag, v, exp[i]);
    end
  endtask

  // mode 0: no host clear, 1: normal clear, 2: clear on the posting edge
  task automatic exchange(input int p, input int mode);
    logic [7:0] exp [NS];
    logic [7:0] v;
    for (int i = 0; i < NS; i++) begin
      exp[i] = pat(p, i);
      stat_in[i*8 +: 8] = exp[i];
    end
    wr(8'h50, 8'h33);
    rd(8'h50, v); chk("R2 request pending", v, 8'h33);
    chk("R4 irq not early", {7'd0, irq}, 8'h00);
    @(negedge clk);
    stat_in = ~stat_in;                          // after the capture edge
    if (mode == 2) begin
      repeat (NS - 1) @(negedge clk);
      wr(8'h58, 8'h00);                          // sampled on posting edge
      chk("R10 post wins irq", {7'd0, irq}, 8'h01);
      rd(8'h58, v); chk("R10 post wins code", v, 8'h34);
    end else begin
      repeat (NS) @(negedge clk);
      chk("R4 not before N+2", {7'd0, irq}, 8'h00);
      rd(8'h50, v); chk("R2 still pending", v, 8'h33);
      @(negedge clk);
      chk("R4 irq raised", {7'd0, irq}, 8'h01);
      rd(8'h58, v); chk("R4 response code", v, 8'h34);
      rd(8'h50, v); chk("R4 request cleared", v, 8'h00);
    end
    check_mbx("R3 snapshot", exp);
    stat_in = {NS{8'hA5}};
    wr(8'h50, 8'h33);
    rd(8'h50, v); chk("R8 busy request ignored", v, 8'h00);
    chk("R8 irq level kept", {7'd0, irq}, 8'h01);
    repeat (NS + 3) @(negedge clk);
    check_mbx("R8 mailbox unchanged", exp);
    if (mode == 1) begin
      wr(8'h58, 8'h00);
      chk("R6 irq cleared", {7'd0, irq}, 8'h00);
      rd(8'h58, v); chk("R6 code cleared", v, 8'h00);
      repeat (3) @(negedge clk);
      chk("R6 stays clear", {7'd0, irq}, 8'h00);
    end else begin
      repeat (3) @(negedge clk);
      chk("R5 irq held", {7'd0, irq}, 8'h01);
    end
    wr(8'h50, 8'h35);
    rd(8'h50, v); chk("R7 ack visible", v, 8'h35);
    @(negedge clk);
    rd(8'h50, v); chk("R7 cmd cleared", v, 8'h00);
    rd(8'h58, v); chk("R7 rsp cleared", v, 8'h00);
    chk("R7 irq low", {7'd0, irq}, 8'h00);
    chk("R5 irq matches flag", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] zero [NS];
    for (int i = 0; i < NS; i++) zero[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
    rd(8'h50, v); chk("R1 cmd reset", v, 8'h00);
    rd(8'h58, v); chk("R1 rsp reset", v, 8'h00);
    check_mbx("R1 mailbox reset", zero);

    for (int c = 0; c < 256; c++) begin
      if (c == 'h33) continue;
      wr(8'h50, 8'(c));
      rd(8'h50, v); chk("R9 other code ignored", v, 8'h00);
      chk("R9 irq stays low", {7'd0, irq}, 8'h00);
    end

    for (int p = 0; p < 9; p++) exchange(p, p % 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule